// File: doc/BRIEF.md
# Fill-Mode Trace Buffer Writer

This block takes a byte-wide stream of trace data and stores it in memory, one byte per write, inside a window that software programs. The window starts at a base address and ends just below a limit address. Writing begins at a programmed write pointer. Software reaches the block through a small register port with four registers: limit/control, base, write pointer and status. Only the limit/control register carries the enable.

Capture runs until the byte just below the limit has been written. The pointer then wraps to the base, collection halts and a level interrupt is raised, with the status recording why. The block never overwrites earlier data in a circle. Software reads out the buffer, clears the status while the block is disabled and enables it again. A memory abort or an external trigger pulse also stops capture, but with a status that software can tell apart from a normal wrap. A drain request holds off new bytes and is acknowledged only after every accepted byte has reached memory. Software uses it before turning the block off.

Top module: `trace_fill_writer`

## Requirements
- R1: After reset the status reads 0, the interrupt output is low, no byte is accepted, no memory write is issued, and the limit, base and write-pointer registers read 0.
- R2: While enabled and not stopped, each accepted byte produces exactly one memory write at the current write pointer. The pointer then advances by one.
- R3: When the write at address limit-1 completes, the write pointer becomes the base. The status then reads 0x47. The status layout is bit0 interrupt pending, bit1 wrap, bit2 stop, bit3 trigger, bits[5:4] cause (0 other, 1 abort) and bits[7:6] buffer code (0 none, 1 filled, 2 fault).
- R4: Once stopped, no further byte is accepted until software clears the status while the block is disabled and then enables it again.
- R5: The interrupt output is a level equal to the interrupt-pending status bit. It stays high until software clears that bit.
- R6: The low PAGE_W bits written to base and limit are dropped (page alignment). The low ALIGN_W bits written to the write pointer are dropped.
- R7: Register map by address: 0 limit/control, 1 base, 2 write pointer, 3 status. The limit/control register is writable at any time and reads back bit0 enable, bits[2:1] fill mode, bits[4:3] trigger mode and the limit page in bits PAGE_W and up. Clearing enable keeps the limit address.
- R8: Writes to base, write pointer or status are ignored while the block is enabled or a byte is still pending.
- R9: A write completing with the abort input high is dropped and leaves the write pointer unchanged. The status then reads 0x95 (interrupt, stop, cause abort, code fault).
- R10: A trigger pulse while capturing stops the block and sets the status to 0x0D (interrupt, stop, trigger).
- R11: While drain is requested no byte is accepted. The drain acknowledge rises only after all accepted bytes have been written.
- R12: While a memory write waits for ready, its address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tv_valid_i | input | 1 | Trace byte valid |
| tv_data_i | input | 8 | Trace byte |
| tv_ready_o | output | 1 | Trace byte accepted when high with valid |
| trig_i | input | 1 | Trigger pulse, stops capture as fatal |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_data_o | output | 8 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| mem_abort_i | input | 1 | Write completing this cycle has faulted |
| drain_req_i | input | 1 | Drain request |
| drain_ack_o | output | 1 | All accepted bytes have been written |
| irq_o | output | 1 | Maintenance interrupt level |

## Verification
The assertions take for granted that software programs the write pointer inside the window and the base below the limit. They also assume the memory side raises abort only together with ready, and that the status is cleared only while the block is disabled. The stimulus follows these rules. Every buffer is set up with the block disabled, each pointer sits inside its window, and abort is held high only around a single write. Ready is either held high, toggled every other cycle, or held low for a while during the drain case, so that the stability checks on a waiting write are exercised.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 32;

  typedef enum logic [1:0] {
    REG_LIMIT  = 2'd0,
    REG_BASE   = 2'd1,
    REG_WPTR   = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CAUSE_OTHER = 2'd0,
    CAUSE_ABORT = 2'd1
  } cause_e;

  typedef enum logic [1:0] {
    BUF_NONE   = 2'd0,
    BUF_FILLED = 2'd1,
    BUF_FAULT  = 2'd2
  } buf_code_e;

  typedef struct packed {
    buf_code_e bcode;
    cause_e    cause;
    logic      trg;
    logic      stop;
    logic      wrap;
    logic      irq;
  } status_t;
endpackage

// File: rtl/tfw_ctrl.sv
module tfw_ctrl
  import tfw_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int ALIGN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              abort_i,
  input  logic              trig_i,
  output logic              run_o,
  output logic              at_last_o,
  output logic [ADDR_W-1:0] wptr_o,
  output logic              irq_o
);
  localparam int PN_W = ADDR_W - PAGE_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic            en_q;
  logic [1:0]      fill_q, tmode_q;
  logic [PN_W-1:0] limit_q, base_q;
  logic [ADDR_W-1:0] wptr_q;
  status_t         st_q;

  logic [ADDR_W-1:0] base_addr, limit_addr;
  logic locked;
  reg_sel_e sel;

  assign sel        = reg_sel_e'(reg_addr_i);
  assign base_addr  = {base_q, {PAGE_W{1'b0}}};
  assign limit_addr = {limit_q, {PAGE_W{1'b0}}};
  assign locked     = en_q | busy_i;
  assign run_o      = en_q & ~st_q.stop;
  assign at_last_o  = (wptr_q == limit_addr - ONE);
  assign wptr_o     = wptr_q;
  assign irq_o      = st_q.irq;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[REG_W-1:ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      fill_q  <= '0;
      tmode_q <= '0;
      limit_q <= '0;
      base_q  <= '0;
      wptr_q  <= '0;
      st_q    <= '0;
    end else begin
      if (reg_wr_i) begin
        unique case (sel)
          REG_LIMIT: begin
            en_q    <= reg_wdata_i[0];
            fill_q  <= reg_wdata_i[2:1];
            tmode_q <= reg_wdata_i[4:3];
            limit_q <= reg_wdata_i[ADDR_W-1:PAGE_W];
          end
          REG_BASE:   if (!locked) base_q <= reg_wdata_i[ADDR_W-1:PAGE_W];
          REG_WPTR:   if (!locked) wptr_q <= {reg_wdata_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
          REG_STATUS: if (!locked) st_q <= status_t'(reg_wdata_i[7:0]);
          default: ;
        endcase
      end
      if (done_i) begin
        if (at_last_o) begin
          wptr_q     <= base_addr;
          st_q.irq   <= 1'b1;
          st_q.wrap  <= 1'b1;
          st_q.stop  <= 1'b1;
          st_q.cause <= CAUSE_OTHER;
          st_q.bcode <= BUF_FILLED;
        end else begin
          wptr_q <= wptr_q + ONE;
        end
      end
      if (abort_i) begin
        st_q.irq   <= 1'b1;
        st_q.stop  <= 1'b1;
        st_q.cause <= CAUSE_ABORT;
        st_q.bcode <= BUF_FAULT;
      end
      if (trig_i && run_o) begin
        st_q.irq  <= 1'b1;
        st_q.trg  <= 1'b1;
        st_q.stop <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      REG_LIMIT:  reg_rdata_o = REG_W'({limit_q, {(PAGE_W-5){1'b0}}, tmode_q, fill_q, en_q});
      REG_BASE:   reg_rdata_o = REG_W'(base_addr);
      REG_WPTR:   reg_rdata_o = REG_W'(wptr_q);
      REG_STATUS: reg_rdata_o = REG_W'(st_q);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tfw_stage.sv
module tfw_stage
  import tfw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              at_last_i,
  input  logic [ADDR_W-1:0] wptr_i,
  input  logic              tv_valid_i,
  input  logic [BYTE_W-1:0] tv_data_i,
  output logic              tv_ready_o,
  input  logic              trig_i,
  input  logic              drain_req_i,
  output logic              drain_ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_data_o,
  input  logic              mem_ready_i,
  input  logic              mem_abort_i,
  output logic              done_o,
  output logic              abort_o,
  output logic              busy_o
);
  logic              hold_q;
  logic [BYTE_W-1:0] data_q;
  logic              accept, retire, slot_free;

  assign retire    = hold_q & mem_ready_i;
  assign done_o    = retire & ~mem_abort_i;
  assign abort_o   = retire & mem_abort_i;
  // a slot frees in the same cycle only if the retiring byte neither faults nor ends the window
  assign slot_free = ~hold_q | (mem_ready_i & ~mem_abort_i & ~at_last_i);
  assign tv_ready_o = run_i & ~drain_req_i & ~trig_i & slot_free;
  assign accept    = tv_valid_i & tv_ready_o;

  assign mem_we_o   = hold_q;
  assign mem_addr_o = wptr_i;
  assign mem_data_o = data_q;
  assign busy_o     = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      data_q      <= '0;
      drain_ack_o <= 1'b0;
    end else begin
      if (accept) begin
        hold_q <= 1'b1;
        data_q <= tv_data_i;
      end else if (retire) begin
        hold_q <= 1'b0;
      end
      drain_ack_o <= drain_req_i & ~hold_q;
    end
  end
endmodule

// File: rtl/trace_fill_writer.sv
module trace_fill_writer
  import tfw_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int ALIGN_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tv_valid_i,
  input  logic [7:0]        tv_data_i,
  output logic              tv_ready_o,
  input  logic              trig_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  input  logic              mem_ready_i,
  input  logic              mem_abort_i,
  input  logic              drain_req_i,
  output logic              drain_ack_o,
  output logic              irq_o
);
  logic run, at_last, busy, done, abort;
  logic [ADDR_W-1:0] wptr;

  tfw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .abort_i(abort), .trig_i(trig_i),
    .run_o(run), .at_last_o(at_last), .wptr_o(wptr), .irq_o(irq_o)
  );

  tfw_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(run), .at_last_i(at_last), .wptr_i(wptr),
    .tv_valid_i(tv_valid_i), .tv_data_i(tv_data_i), .tv_ready_o(tv_ready_o),
    .trig_i(trig_i), .drain_req_i(drain_req_i), .drain_ack_o(drain_ack_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .mem_ready_i(mem_ready_i), .mem_abort_i(mem_abort_i),
    .done_o(done), .abort_o(abort), .busy_o(busy)
  );
endmodule

// File: rtl/tfw_checker.sv
module tfw_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tv_ready_o,
  input logic              drain_req_i,
  input logic              drain_ack_o,
  input logic              mem_we_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_data_o,
  input logic              irq_o,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i
);
  assert_irq_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(reg_wr_i && reg_addr_i == 2'd3) |=> irq_o);

  assert_halt_on_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !tv_ready_o);

  assert_drain_flushed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_ack_o |-> !mem_we_o);

  assert_drain_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_req_i |-> !tv_ready_o);

  assert_req_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_ready_i |=> mem_we_o && $stable(mem_addr_o) && $stable(mem_data_o));
endmodule

bind trace_fill_writer tfw_checker #(.ADDR_W(ADDR_W)) u_tfw_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .tv_ready_o(tv_ready_o),
  .drain_req_i(drain_req_i), .drain_ack_o(drain_ack_o),
  .mem_we_o(mem_we_o), .mem_ready_i(mem_ready_i),
  .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .irq_o(irq_o), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i)
);

// File: tb/trace_fill_writer_tb_top.sv
module trace_fill_writer_tb_top;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;
  localparam int ALIGN_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic tv_valid = 1'b0, trig = 1'b0, reg_wr = 1'b0, mem_abort = 1'b0, drain_req = 1'b0;
  logic [7:0] tv_data = '0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tv_ready, mem_we, mem_ready, drain_ack, irq;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data;
  logic stall = 1'b0, mem_gate = 1'b1;
  logic [15:0] cyc = '0;

  assign mem_ready = mem_gate & (~stall | cyc[0]);

  trace_fill_writer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tv_valid_i(tv_valid), .tv_data_i(tv_data),
    .tv_ready_o(tv_ready), .trig_i(trig), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ready_i(mem_ready),
    .mem_abort_i(mem_abort), .drain_req_i(drain_req), .drain_ack_o(drain_ack), .irq_o(irq)
  );

  int wcount = 0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [7:0] last_data = '0;
  always @(posedge clk) begin
    cyc <= cyc + 16'd1;
    if (rst_ni && mem_we && mem_ready && !mem_abort) begin
      wcount    <= wcount + 1;
      last_addr <= mem_addr;
      last_data <= mem_data;
    end
  end

  int tests = 0, fails = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] d, output logic ok);
    ok = 1'b0;
    tv_valid = 1'b1; tv_data = d;
    for (int t = 0; t < 30; t++) begin
      if (tv_ready) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (ok) @(negedge clk);
    tv_valid = 1'b0;
  endtask

  task automatic setup(input logic [7:0] bp, input logic [7:0] lp, input logic [15:0] wp);
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h0);
    wr(2'd1, {16'h0, bp, 8'h00});
    wr(2'd2, {16'h0, wp});
    wr(2'd0, {16'h0, lp, 8'h01});
  endtask

  typedef struct packed {
    logic [7:0]  bp;
    logic [7:0]  lp;
    logic [15:0] wp;
    logic [7:0]  n;
    logic [15:0] exp_wp;
    logic [15:0] exp_last;
    logic        exp_irq;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'h01, 8'h03, 16'h0100, 8'd10, 16'h010A, 16'h0109, 1'b0, 1'b0},
    '{8'h02, 8'h03, 16'h02F8, 8'd8,  16'h0200, 16'h02FF, 1'b1, 1'b0},
    '{8'h04, 8'h05, 16'h04FC, 8'd3,  16'h04FF, 16'h04FE, 1'b0, 1'b1},
    '{8'h05, 8'h06, 16'h05F0, 8'd16, 16'h0500, 16'h05FF, 1'b1, 1'b1},
    '{8'h03, 8'h05, 16'h0300, 8'd40, 16'h0328, 16'h0327, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic ok;
    int w0;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(2'd3, r); check("R1 status", r, 32'h0);
    rd(2'd0, r); check("R1 limit", r, 32'h0);
    rd(2'd1, r); check("R1 base", r, 32'h0);
    rd(2'd2, r); check("R1 wptr", r, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 ready/we", {30'h0, tv_ready, mem_we}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2/R3: vector table
    for (int v = 0; v < 5; v++) begin
      stall = VEC[v].stall;
      setup(VEC[v].bp, VEC[v].lp, VEC[v].wp);
      w0 = wcount;
      for (int i = 0; i < int'(VEC[v].n); i++) begin
        send(8'(v * 16 + i), ok);
        check("R2 accept", {31'h0, ok}, 32'h1);
      end
      repeat (6) @(negedge clk);
      rd(2'd2, r); check("R2/R3 wptr", r, {16'h0, VEC[v].exp_wp});
      rd(2'd3, r); check("R3 status", r, VEC[v].exp_irq ? 32'h47 : 32'h0);
      check("R5 irq", {31'h0, irq}, {31'h0, VEC[v].exp_irq});
      check("R2 count", 32'(wcount - w0), 32'(VEC[v].n));
      check("R2 last addr", {16'h0, last_addr}, {16'h0, VEC[v].exp_last});
      check("R2 last data", {24'h0, last_data}, 32'(8'(v * 16 + int'(VEC[v].n) - 1)));
    end
    stall = 1'b0;

    // R4/R5/R7/R8: wrap then halt
    setup(8'h06, 8'h07, 16'h06FC);
    for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i), ok);
    repeat (3) @(negedge clk);
    w0 = wcount;
    send(8'hEE, ok);
    check("R4 no accept after wrap", {31'h0, ok}, 32'h0);
    check("R4 no write after wrap", 32'(wcount - w0), 32'h0);
    check("R5 irq held", {31'h0, irq}, 32'h1);
    wr(2'd3, 32'h0);
    rd(2'd3, r); check("R8 status write ignored", r, 32'h47);
    check("R5 irq after ignored clear", {31'h0, irq}, 32'h1);
    wr(2'd1, 32'h0900);
    rd(2'd1, r); check("R8 base write ignored", r, 32'h0600);
    wr(2'd2, 32'h0000);
    rd(2'd2, r); check("R8 wptr write ignored", r, 32'h0600);
    rd(2'd0, r); check("R7 limit readback", r, 32'h0701);
    wr(2'd0, 32'h071A);
    rd(2'd0, r); check("R7 disable keeps limit", r, 32'h071A);
    check("R5 irq until cleared", {31'h0, irq}, 32'h1);
    wr(2'd3, 32'h0);
    check("R5 irq cleared", {31'h0, irq}, 32'h0);
    rd(2'd3, r); check("R5 status cleared", r, 32'h0);

    // R6: alignment
    wr(2'd1, 32'h0AFF);
    rd(2'd1, r); check("R6 base align", r, 32'h0A00);
    wr(2'd2, 32'h0A13);
    rd(2'd2, r); check("R6 wptr align", r, 32'h0A10);
    wr(2'd0, 32'h0B54);
    rd(2'd0, r); check("R6 limit align", r, 32'h0B14);

    // R9: abort
    setup(8'h0A, 8'h0B, 16'h0A10);
    mem_abort = 1'b1;
    send(8'h5A, ok);
    repeat (3) @(negedge clk);
    mem_abort = 1'b0;
    rd(2'd3, r); check("R9 abort status", r, 32'h95);
    rd(2'd2, r); check("R9 wptr unchanged", r, 32'h0A10);
    check("R9 irq", {31'h0, irq}, 32'h1);

    // R10: trigger
    setup(8'h0A, 8'h0B, 16'h0A10);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk);
    rd(2'd3, r); check("R10 trigger status", r, 32'h0D);
    check("R10 halted", {31'h0, tv_ready}, 32'h0);

    // R11/R12: drain
    setup(8'h0A, 8'h0B, 16'h0A20);
    mem_gate = 1'b0;
    w0 = wcount;
    send(8'h77, ok);
    drain_req = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 no ack while pending", {31'h0, drain_ack}, 32'h0);
    check("R12 request held", {31'h0, mem_we}, 32'h1);
    check("R12 addr held", {16'h0, mem_addr}, 32'h0A20);
    check("R11 blocked during drain", {31'h0, tv_ready}, 32'h0);
    mem_gate = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 ack after flush", {31'h0, drain_ack}, 32'h1);
    check("R11 byte written", 32'(wcount - w0), 32'h1);
    check("R11 data", {24'h0, last_data}, 32'h77);
    drain_req = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule